// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between an SRAM-style write bus and the write machinery of a byte-wide NOR flash array built from equal-sized erase blocks. A write cycle is taken when the write strobe rises. The block decodes one-cycle and two-cycle command sequences. It decides whether reads return array data, the status byte or identifier codes. It also launches erase and program requests toward an external array model, or runs lock-bit updates itself.

Protection comes from per-block lock bits and a one-way master lock. A high-voltage reset flag can override some of these locks, and a supply-lockout flag blocks every change. A running erase or program can be parked with a suspend command. While an erase is parked, a program may run in its place. The ready output tells software when a new operation may start.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write is taken once per rising edge of `we_i`, however long the strobe then stays high. The byte and address are captured at that edge.
- R2: Command FFh selects array reads, which return `arr_rdata_i`. Command 70h selects status reads. Command 90h selects identifier reads, decoded by read address bits [1:0]: 0 gives `MFR_ID`, 1 gives `DEV_ID`, 2 gives the lock bit of the addressed block in bit 0, and 3 gives the master lock in bit 0.
- R3: The status byte has ready in bit 7 and erase-suspended in bit 6. The error bits are erase error in bit 5, program error in bit 4 and supply-lockout error in bit 3. Program-suspended is bit 2, lock violation is bit 1, and bit 0 reads zero.
- R4: Command 20h followed by D0h starts one erase request at the second cycle's address. `ready_o` stays low until `arr_done_i`, and reads switch to status.
- R5: Command 40h or 10h followed by a data cycle starts one program request carrying that cycle's address and data byte.
- R6: An erase or program aimed at a locked block is refused unless `hv_rst_i` is high. A refused erase sets bits 5 and 1. A refused program sets bits 4 and 1.
- R7: Command 60h is followed by a second byte. 01h sets the addressed block's lock. F1h sets the master lock, which always needs `hv_rst_i`. D0h clears every block lock. Setting or clearing a block lock needs `hv_rst_i` only while the master lock is set. A lock operation keeps `ready_o` low for `LOCK_CYC` cycles. A refused set raises bits 4 and 1, and a refused clear raises bits 5 and 1. The master lock never clears.
- R8: While `vpp_lock_i` is high, no erase or program request issues and no lock bit changes. The attempt sets bit 3 together with bit 4 (program or lock set) or bit 5 (erase or lock clear).
- R9: A second-cycle byte that does not match its sequence sets bits 5 and 4, starts nothing, and leaves reads in status mode.
- R10: Error bits stay set until command 50h clears them.
- R11: Command B0h during a program parks it: `prog_hold_o` goes high, `ready_o` goes high and status bit 2 is set. Only FFh, 70h and D0h are then acted on, and D0h resumes the program.
- R12: Command B0h during an erase parks it: `erase_hold_o` goes high and status bit 6 is set. A program may then run. D0h resumes the erase once no program is active.
- R13: `ready_o` is high whenever `pwr_down_i` is high.
- R14: While an operation runs unparked, only 70h and B0h are acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | $clog2(NBLK)+BLK_AW | Bus address, block index in the upper bits |
| data_i | input | 8 | Write data byte |
| we_i | input | 1 | Write strobe, taken on its rising edge |
| hv_rst_i | input | 1 | High-voltage reset flag, lock override |
| vpp_lock_i | input | 1 | Programming-supply lockout flag |
| pwr_down_i | input | 1 | Power-down indication |
| rd_data_o | output | 8 | Read data for the selected read mode |
| ready_o | output | 1 | High when no operation is running |
| arr_start_o | output | 1 | One-cycle request pulse to the array |
| arr_erase_o | output | 1 | Request kind: 1 erase, 0 program |
| arr_addr_o | output | $clog2(NBLK)+BLK_AW | Request address |
| arr_data_o | output | 8 | Program data |
| arr_rdata_i | input | 8 | Array read data |
| arr_done_i | input | 1 | Completion pulse for the running request |
| erase_hold_o | output | 1 | Erase parked |
| prog_hold_o | output | 1 | Program parked |

## Verification
The bench builds the block with eight blocks of sixteen bytes and a three-cycle lock operation. With a seven-bit address, a random block pick lands on every lock bit many times within a short run. Identifier reads for any block then need only a few cycles. The short lock time keeps each random lock attempt brief, so dozens of attempts fit in the run. Because the master lock is set before the random phase, every random lock attempt depends on the high-voltage flag.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam logic [7:0] CMD_READ  = 8'hFF;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_PRG_A = 8'h40;
  localparam logic [7:0] CMD_PRG_B = 8'h10;
  localparam logic [7:0] CMD_LOCK  = 8'h60;
  localparam logic [7:0] LK_BLOCK  = 8'h01;
  localparam logic [7:0] LK_MASTER = 8'hF1;

  localparam int ST_READY = 7;
  localparam int ST_ESUSP = 6;
  localparam int ST_EERR  = 5;
  localparam int ST_PERR  = 4;
  localparam int ST_VERR  = 3;
  localparam int ST_PSUSP = 2;
  localparam int ST_LVIOL = 1;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT} rd_mode_e;
  typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_PROG, PD_LOCK} pend_e;
  typedef enum logic [1:0] {LKK_BLOCK, LKK_MASTER, LKK_CLEAR} lk_kind_e;
endpackage

// File: rtl/fci_strobe.sv
module fci_strobe #(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  logic we_q;
  logic rise;

  assign rise = we_i & ~we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q      <= 1'b0;
      wr_vld_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      we_q     <= we_i;
      wr_vld_o <= rise;
      if (rise) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end
  end

  assert_vld_from_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> $past(we_i));
endmodule

// File: rtl/fci_lock_bank.sv
module fci_lock_bank #(
  parameter int NBLK  = 32,
  parameter int BLK_W = $clog2(NBLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_blk_i,
  input  logic             set_mst_i,
  input  logic             clr_all_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [NBLK-1:0]  locks_o,
  output logic             master_o
);
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   bit_q <= 1'b0;
      else if (clr_all_i)                            bit_q <= 1'b0;
      else if (set_blk_i && blk_i == BLK_W'(b))      bit_q <= 1'b1;
    end
    assign locks_o[b] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        master_o <= 1'b0;
    else if (set_mst_i) master_o <= 1'b1;
  end

  assert_master_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |=> master_o);
endmodule

// File: rtl/fci_seq.sv
module fci_seq
  import fci_pkg::*;
#(
  parameter int NBLK     = 32,
  parameter int BLK_AW   = 16,
  parameter int LOCK_CYC = 4,
  parameter int ADDR_W   = $clog2(NBLK) + BLK_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              hv_rst_i,
  input  logic              vpp_lock_i,
  input  logic              arr_done_i,
  input  logic [NBLK-1:0]   locks_i,
  input  logic              master_i,
  output rd_mode_e          rd_mode_o,
  output logic [7:0]        sts_o,
  output logic              busy_o,
  output logic              arr_start_o,
  output logic              arr_erase_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_data_o,
  output logic              erase_hold_o,
  output logic              prog_hold_o,
  output logic              lk_set_blk_o,
  output logic              lk_set_mst_o,
  output logic              lk_clr_all_o,
  output logic [$clog2(NBLK)-1:0] lk_blk_o
);
  localparam int BLK_W = $clog2(NBLK);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);

  pend_e           pend_q;
  logic            er_act_q, er_held_q, pg_act_q, pg_held_q, lk_act_q;
  logic [CNT_W-1:0] lk_cnt_q;
  lk_kind_e        lk_kind_q;
  logic [7:0]      err_q;
  logic [BLK_W-1:0] wr_blk;
  logic            blk_locked, lk_ok, lk_clr;

  assign wr_blk     = wr_addr_i[ADDR_W-1:BLK_AW];
  assign blk_locked = locks_i[wr_blk];
  assign busy_o     = (er_act_q & ~er_held_q) | (pg_act_q & ~pg_held_q) | lk_act_q;
  assign erase_hold_o = er_held_q;
  assign prog_hold_o  = pg_held_q;
  assign lk_clr     = (wr_data_i == CMD_CONF);
  assign lk_ok      = (wr_data_i == LK_MASTER) ? hv_rst_i : (!master_i || hv_rst_i);

  always_comb begin
    sts_o           = err_q;
    sts_o[ST_READY] = ~busy_o;
    sts_o[ST_ESUSP] = er_held_q;
    sts_o[ST_PSUSP] = pg_held_q;
    sts_o[0]        = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_mode_o <= RD_ARRAY;
      pend_q    <= PD_NONE;
      er_act_q  <= 1'b0;
      er_held_q <= 1'b0;
      pg_act_q  <= 1'b0;
      pg_held_q <= 1'b0;
      lk_act_q  <= 1'b0;
      lk_cnt_q  <= '0;
      lk_kind_q <= LKK_BLOCK;
      lk_blk_o  <= '0;
      err_q     <= '0;
      arr_start_o <= 1'b0;
      arr_erase_o <= 1'b0;
      arr_addr_o  <= '0;
      arr_data_o  <= '0;
      lk_set_blk_o <= 1'b0;
      lk_set_mst_o <= 1'b0;
      lk_clr_all_o <= 1'b0;
    end else begin
      arr_start_o  <= 1'b0;
      lk_set_blk_o <= 1'b0;
      lk_set_mst_o <= 1'b0;
      lk_clr_all_o <= 1'b0;

      if (arr_done_i) begin
        if (pg_act_q && !pg_held_q)      pg_act_q <= 1'b0;
        else if (er_act_q && !er_held_q) er_act_q <= 1'b0;
      end

      if (lk_act_q) begin
        if (lk_cnt_q == CNT_W'(LOCK_CYC - 1)) begin
          lk_act_q     <= 1'b0;
          lk_set_blk_o <= (lk_kind_q == LKK_BLOCK);
          lk_set_mst_o <= (lk_kind_q == LKK_MASTER);
          lk_clr_all_o <= (lk_kind_q == LKK_CLEAR);
        end else begin
          lk_cnt_q <= lk_cnt_q + 1'b1;
        end
      end

      if (wr_vld_i) begin
        if (pend_q != PD_NONE) begin
          pend_q    <= PD_NONE;
          rd_mode_o <= RD_STATUS;
          case (pend_q)
            PD_ERASE: begin
              if (wr_data_i != CMD_CONF)
                err_q <= err_q | 8'(1 << ST_EERR) | 8'(1 << ST_PERR);
              else if (vpp_lock_i)
                err_q <= err_q | 8'(1 << ST_EERR) | 8'(1 << ST_VERR);
              else if (blk_locked && !hv_rst_i)
                err_q <= err_q | 8'(1 << ST_EERR) | 8'(1 << ST_LVIOL);
              else begin
                er_act_q    <= 1'b1;
                arr_start_o <= 1'b1;
                arr_erase_o <= 1'b1;
                arr_addr_o  <= wr_addr_i;
                arr_data_o  <= 8'hFF;
              end
            end
            PD_PROG: begin
              if (vpp_lock_i)
                err_q <= err_q | 8'(1 << ST_PERR) | 8'(1 << ST_VERR);
              else if (blk_locked && !hv_rst_i)
                err_q <= err_q | 8'(1 << ST_PERR) | 8'(1 << ST_LVIOL);
              else begin
                pg_act_q    <= 1'b1;
                arr_start_o <= 1'b1;
                arr_erase_o <= 1'b0;
                arr_addr_o  <= wr_addr_i;
                arr_data_o  <= wr_data_i;
              end
            end
            PD_LOCK: begin
              if (wr_data_i != LK_BLOCK && wr_data_i != LK_MASTER && !lk_clr)
                err_q <= err_q | 8'(1 << ST_EERR) | 8'(1 << ST_PERR);
              else if (vpp_lock_i)
                err_q <= err_q | 8'(1 << (lk_clr ? ST_EERR : ST_PERR)) | 8'(1 << ST_VERR);
              else if (!lk_ok)
                err_q <= err_q | 8'(1 << (lk_clr ? ST_EERR : ST_PERR)) | 8'(1 << ST_LVIOL);
              else begin
                lk_act_q  <= 1'b1;
                lk_cnt_q  <= '0;
                lk_blk_o  <= wr_blk;
                lk_kind_q <= lk_clr ? LKK_CLEAR :
                             (wr_data_i == LK_MASTER) ? LKK_MASTER : LKK_BLOCK;
              end
            end
            default: ;
          endcase
        end else if (busy_o) begin
          if (wr_data_i == CMD_STAT) rd_mode_o <= RD_STATUS;
          else if (wr_data_i == CMD_SUSP && !arr_done_i) begin
            rd_mode_o <= RD_STATUS;
            if (pg_act_q && !pg_held_q)      pg_held_q <= 1'b1;
            else if (er_act_q && !er_held_q) er_held_q <= 1'b1;
          end
        end else if (pg_held_q) begin
          case (wr_data_i)
            CMD_READ: rd_mode_o <= RD_ARRAY;
            CMD_STAT: rd_mode_o <= RD_STATUS;
            CMD_CONF: begin pg_held_q <= 1'b0; rd_mode_o <= RD_STATUS; end
            default: ;
          endcase
        end else if (er_held_q) begin
          case (wr_data_i)
            CMD_READ: rd_mode_o <= RD_ARRAY;
            CMD_STAT: rd_mode_o <= RD_STATUS;
            CMD_PRG_A, CMD_PRG_B: pend_q <= PD_PROG;
            CMD_CONF: begin er_held_q <= 1'b0; rd_mode_o <= RD_STATUS; end
            default: ;
          endcase
        end else begin
          case (wr_data_i)
            CMD_READ:  rd_mode_o <= RD_ARRAY;
            CMD_STAT:  rd_mode_o <= RD_STATUS;
            CMD_IDENT: rd_mode_o <= RD_IDENT;
            CMD_CLR:   err_q <= '0;
            CMD_ERASE: pend_q <= PD_ERASE;
            CMD_PRG_A, CMD_PRG_B: pend_q <= PD_PROG;
            CMD_LOCK:  pend_q <= PD_LOCK;
            default: ;
          endcase
        end
      end
    end
  end

  assert_start_needs_supply_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |-> !$past(vpp_lock_i));
  assert_start_not_busy_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |-> !$past(busy_o));
  assert_prog_hold_active_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_held_q |-> pg_act_q);
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(err_q) & ~err_q)) |-> $past(wr_vld_i && wr_data_i == CMD_CLR));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fci_pkg::*;
#(
  parameter int         NBLK     = 32,
  parameter int         BLK_AW   = 16,
  parameter int         LOCK_CYC = 4,
  parameter logic [7:0] MFR_ID   = 8'h3C,
  parameter logic [7:0] DEV_ID   = 8'hA7
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [$clog2(NBLK)+BLK_AW-1:0]   addr_i,
  input  logic [7:0]                       data_i,
  input  logic                             we_i,
  input  logic                             hv_rst_i,
  input  logic                             vpp_lock_i,
  input  logic                             pwr_down_i,
  output logic [7:0]                       rd_data_o,
  output logic                             ready_o,
  output logic                             arr_start_o,
  output logic                             arr_erase_o,
  output logic [$clog2(NBLK)+BLK_AW-1:0]   arr_addr_o,
  output logic [7:0]                       arr_data_o,
  input  logic [7:0]                       arr_rdata_i,
  input  logic                             arr_done_i,
  output logic                             erase_hold_o,
  output logic                             prog_hold_o
);
  localparam int BLK_W  = $clog2(NBLK);
  localparam int ADDR_W = BLK_W + BLK_AW;

  logic              wr_vld;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [NBLK-1:0]   locks;
  logic              master;
  logic              set_blk, set_mst, clr_all;
  logic [BLK_W-1:0]  lk_blk;
  rd_mode_e          rd_mode;
  logic [7:0]        sts;
  logic              busy;
  logic [BLK_W-1:0]  rd_blk;

  fci_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk_i, .rst_ni, .we_i, .addr_i, .data_i,
    .wr_vld_o(wr_vld), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  fci_lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W)) u_locks (
    .clk_i, .rst_ni,
    .set_blk_i(set_blk), .set_mst_i(set_mst), .clr_all_i(clr_all),
    .blk_i(lk_blk), .locks_o(locks), .master_o(master)
  );

  fci_seq #(.NBLK(NBLK), .BLK_AW(BLK_AW), .LOCK_CYC(LOCK_CYC), .ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .wr_vld_i(wr_vld), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hv_rst_i, .vpp_lock_i, .arr_done_i,
    .locks_i(locks), .master_i(master),
    .rd_mode_o(rd_mode), .sts_o(sts), .busy_o(busy),
    .arr_start_o, .arr_erase_o, .arr_addr_o, .arr_data_o,
    .erase_hold_o, .prog_hold_o,
    .lk_set_blk_o(set_blk), .lk_set_mst_o(set_mst), .lk_clr_all_o(clr_all),
    .lk_blk_o(lk_blk)
  );

  assign rd_blk  = addr_i[ADDR_W-1:BLK_AW];
  assign ready_o = ~busy | pwr_down_i;

  always_comb begin
    case (rd_mode)
      RD_STATUS: rd_data_o = sts;
      RD_IDENT: begin
        case (addr_i[1:0])
          2'd0:    rd_data_o = MFR_ID;
          2'd1:    rd_data_o = DEV_ID;
          2'd2:    rd_data_o = {7'b0, locks[rd_blk]};
          default: rd_data_o = {7'b0, master};
        endcase
      end
      default: rd_data_o = arr_rdata_i;
    endcase
  end

  assert_pd_ready_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> ready_o);
endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int NBLK = 8, BLK_AW = 4, LOCK_CYC = 3, AW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0, arr_rdata_i = 8'h5A;
  logic we_i = 0, hv = 0, vpp = 0, pd = 0, done_i = 0;
  logic [7:0] rd_data_o, arr_data_o;
  logic ready_o, arr_start_o, arr_erase_o, erase_hold_o, prog_hold_o;
  logic [AW-1:0] arr_addr_o;

  int checks = 0, fails = 0, n_start = 0;
  logic m_erase; logic [AW-1:0] m_addr; logic [7:0] m_data;
  bit lock_m [NBLK];

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.NBLK(NBLK), .BLK_AW(BLK_AW), .LOCK_CYC(LOCK_CYC),
                   .MFR_ID(8'h3C), .DEV_ID(8'hA7)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i, .data_i, .we_i,
    .hv_rst_i(hv), .vpp_lock_i(vpp), .pwr_down_i(pd),
    .rd_data_o, .ready_o, .arr_start_o, .arr_erase_o, .arr_addr_o, .arr_data_o,
    .arr_rdata_i, .arr_done_i(done_i), .erase_hold_o, .prog_hold_o
  );

  always @(negedge clk) if (arr_start_o) begin
    n_start++; m_erase = arr_erase_o; m_addr = arr_addr_o; m_data = arr_data_o;
  end

  function automatic logic [7:0] st(bit rdy, bit es, bit ee, bit pe, bit ve, bit ps, bit lv);
    return {rdy, es, ee, pe, ve, ps, lv, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int hold = 1);
    @(negedge clk); addr_i = a; data_i = d; we_i = 1;
    repeat (hold) @(negedge clk);
    we_i = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr_i = a; #1 d = rd_data_o;
  endtask

  task automatic sts_is(input logic [7:0] e, input string tag);
    logic [7:0] d; rd(0, d); chk(d == e, tag, d, e);
  endtask

  task automatic done();
    @(negedge clk); done_i = 1; @(negedge clk); done_i = 0; @(negedge clk);
  endtask

  task automatic lk_wait(); repeat (LOCK_CYC + 3) @(negedge clk); endtask

  task automatic id_rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    logic [7:0] d; wr(0, 8'h90); rd(a, d); chk(d == e, tag, d, e); wr(0, 8'h70);
  endtask

  task automatic run();
    logic [7:0] d; int s0;
    repeat (3) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    // reset state
    chk(ready_o == 1, "R13 reset ready", ready_o, 1);
    rd(0, d); chk(d == 8'h5A, "R2 reset array read", d, 8'h5A);
    wr(0, 8'h70); sts_is(st(1,0,0,0,0,0,0), "R3 idle status");
    wr(0, 8'h90); rd(0, d); chk(d == 8'h3C, "R2 mfr id", d, 8'h3C);
    rd(1, d); chk(d == 8'hA7, "R2 dev id", d, 8'hA7);
    wr(0, 8'hFF); rd(0, d); chk(d == 8'h5A, "R2 back to array", d, 8'h5A);
    // erase
    s0 = n_start; wr(7'h25, 8'h20); wr(7'h27, 8'hD0);
    chk(n_start == s0 + 1 && m_erase && m_addr == 7'h27, "R4 erase request", m_addr, 7'h27);
    chk(ready_o == 0, "R4 busy", ready_o, 0);
    sts_is(st(0,0,0,0,0,0,0), "R4 busy status");
    done(); chk(ready_o == 1, "R4 ready after done", ready_o, 1);
    // program, long strobe gives one write
    s0 = n_start; wr(7'h30, 8'h10, 4); wr(7'h31, 8'hC3);
    chk(n_start == s0 + 1 && !m_erase && m_data == 8'hC3 && m_addr == 7'h31,
        "R1 R5 program via 10h, held strobe", m_data, 8'hC3);
    done();
    s0 = n_start; wr(7'h12, 8'h40); wr(7'h13, 8'h6E);
    chk(n_start == s0 + 1 && m_data == 8'h6E, "R5 program via 40h", m_data, 8'h6E);
    done();
    // bad second byte, sticky errors
    s0 = n_start; wr(0, 8'h20); wr(0, 8'h33);
    chk(n_start == s0, "R9 no start on bad byte", n_start - s0, 0);
    sts_is(st(1,0,1,1,0,0,0), "R9 bad byte status");
    wr(0, 8'hFF); wr(0, 8'h70); sts_is(st(1,0,1,1,0,0,0), "R10 errors sticky");
    wr(0, 8'h50); sts_is(st(1,0,0,0,0,0,0), "R10 clear status");
    // block lock
    wr(7'h20, 8'h60); wr(7'h20, 8'h01);
    chk(ready_o == 0, "R7 lock op busy", ready_o, 0);
    lk_wait(); id_rd(7'h22, 8'h01, "R7 block 2 locked");
    id_rd(7'h12, 8'h00, "R7 block 1 unlocked");
    s0 = n_start; wr(7'h20, 8'h20); wr(7'h21, 8'hD0);
    chk(n_start == s0, "R6 locked erase refused", n_start - s0, 0);
    sts_is(st(1,0,1,0,0,0,1), "R6 erase lock status");
    wr(0, 8'h50);
    s0 = n_start; wr(7'h2A, 8'h40); wr(7'h2A, 8'h11);
    chk(n_start == s0, "R6 locked program refused", n_start - s0, 0);
    sts_is(st(1,0,0,1,0,0,1), "R6 program lock status");
    wr(0, 8'h50); hv = 1;
    s0 = n_start; wr(7'h2A, 8'h40); wr(7'h2A, 8'h11);
    chk(n_start == s0 + 1 && m_addr == 7'h2A, "R6 override with hv", m_addr, 7'h2A);
    done(); hv = 0;
    // master lock
    wr(0, 8'h60); wr(0, 8'hF1); lk_wait();
    sts_is(st(1,0,0,1,0,0,1), "R7 master needs hv");
    id_rd(7'h03, 8'h00, "R7 master still clear");
    wr(0, 8'h50); hv = 1; wr(0, 8'h60); wr(0, 8'hF1); lk_wait(); hv = 0;
    id_rd(7'h03, 8'h01, "R7 master set");
    wr(0, 8'h60); wr(0, 8'hD0); lk_wait();
    sts_is(st(1,0,1,0,0,0,1), "R7 clear refused under master");
    id_rd(7'h22, 8'h01, "R7 lock kept");
    wr(0, 8'h50); hv = 1; wr(0, 8'h60); wr(0, 8'hD0); lk_wait(); hv = 0;
    id_rd(7'h22, 8'h00, "R7 clear all with hv");
    // supply lockout
    vpp = 1; s0 = n_start; wr(7'h40, 8'h40); wr(7'h40, 8'h99);
    chk(n_start == s0, "R8 no program under lockout", n_start - s0, 0);
    sts_is(st(1,0,0,1,1,0,0), "R8 lockout status");
    wr(0, 8'h50); hv = 1; wr(7'h50, 8'h60); wr(7'h50, 8'h01); lk_wait(); hv = 0;
    sts_is(st(1,0,0,1,1,0,0), "R8 lock set under lockout");
    id_rd(7'h52, 8'h00, "R8 lock unchanged");
    vpp = 0; wr(0, 8'h50);
    // program suspend
    wr(7'h44, 8'h40); wr(7'h44, 8'h5C); wr(0, 8'hB0);
    chk(ready_o == 1 && prog_hold_o == 1, "R11 program parked", {ready_o, prog_hold_o}, 3);
    sts_is(st(1,0,0,0,0,1,0), "R11 suspend status");
    s0 = n_start; wr(7'h60, 8'h20); wr(0, 8'h90);
    chk(n_start == s0, "R11 erase ignored", n_start - s0, 0);
    sts_is(st(1,0,0,0,0,1,0), "R11 ident ignored");
    wr(0, 8'hFF); rd(0, d); chk(d == 8'h5A, "R11 array read while parked", d, 8'h5A);
    wr(0, 8'hD0); chk(ready_o == 0 && prog_hold_o == 0, "R11 resumed", ready_o, 0);
    done();
    // erase suspend with nested program
    wr(7'h60, 8'h20); wr(7'h60, 8'hD0); wr(0, 8'hB0);
    chk(erase_hold_o == 1 && ready_o == 1, "R12 erase parked", erase_hold_o, 1);
    sts_is(st(1,1,0,0,0,0,0), "R12 suspend status");
    s0 = n_start; wr(7'h14, 8'h40); wr(7'h14, 8'h2B);
    chk(n_start == s0 + 1 && !m_erase && m_data == 8'h2B, "R12 program during erase hold", m_data, 8'h2B);
    chk(ready_o == 0, "R12 nested busy", ready_o, 0);
    done(); sts_is(st(1,1,0,0,0,0,0), "R12 back to parked erase");
    wr(0, 8'hD0); chk(ready_o == 0 && erase_hold_o == 0, "R12 erase resumed", ready_o, 0);
    // busy ignores most commands, power-down ready
    wr(0, 8'h90); wr(0, 8'hFF);
    sts_is(st(0,0,0,0,0,0,0), "R14 commands ignored while busy");
    pd = 1; @(negedge clk); chk(ready_o == 1, "R13 ready in power-down", ready_o, 1);
    pd = 0; done(); chk(ready_o == 1, "R12 erase done", ready_o, 1);
    // random phase, master set: every lock change needs hv
    void'($urandom(32'd4021));
    for (int b = 0; b < NBLK; b++) lock_m[b] = 0;
    for (int i = 0; i < 40; i++) begin
      int b; bit h, op; logic [7:0] dv; logic [AW-1:0] a;
      b = $urandom % NBLK; h = $urandom % 2; op = $urandom % 2; dv = 8'($urandom);
      a = {3'(b), 4'($urandom)}; hv = h;
      if (op == 0) begin
        wr(a, 8'h60); wr(a, 8'h01); lk_wait();
        if (h) lock_m[b] = 1;
        sts_is(h ? st(1,0,0,0,0,0,0) : st(1,0,0,1,0,0,1), "R7 random lock status");
      end else begin
        s0 = n_start; wr(a, 8'h10); wr(a, dv);
        if (!lock_m[b] || h) begin
          chk(n_start == s0 + 1 && m_addr == a && m_data == dv, "R5 R6 random program", m_data, dv);
          done();
          sts_is(st(1,0,0,0,0,0,0), "R5 random program status");
        end else begin
          chk(n_start == s0, "R6 random locked program", n_start - s0, 0);
          sts_is(st(1,0,0,1,0,0,1), "R6 random refused status");
        end
      end
      hv = 0; wr(0, 8'h50);
      id_rd({3'(b), 4'h2}, {7'b0, lock_m[b]}, "R2 random lock read");
    end
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule